// File: doc/BRIEF.md
# Multi-Context Folding Logic Cluster

This block is a cluster of four logic elements. Each element has one 4-input lookup table and one flip-flop, plus a private store of sixteen configuration contexts. One sequencer is shared by the whole cluster and selects which context is active. Because that selection can change on any clock cycle, a single table can compute a different Boolean function in successive steps. A multi-stage circuit is therefore folded in time: the flip-flops hold each stage's partial results, and the next context consumes them.

While the sequencer is idle, software loads contexts through a write port. It then chooses a folding level and the index of the last context in use, and pulses start. The sequencer walks from context 0 up to that last index. It holds each context for 1, 2 or 4 cycles, or it keeps context 0 for good when folding is off. After each step a table input can come from the external data pins or from a flip-flop in the cluster.

Top module: `fold_cluster`

## Requirements
- R1: With an element's output-select bit at 0, its output is combinational and equals truth-table bit number {in3,in2,in1,in0}, with in0 the least significant index bit.
- R2: Each of the 4 elements holds 16 contexts. A write stores truth table, output-select bit and source field at the addressed element and context. Only that entry changes.
- R3: After a start pulse, contexts 0 through `ctxLast` become active in ascending order. Every flip-flop loads its table result once per context, on that context's final cycle.
- R4: The folding level code sets the cycles per context: 0 gives 1 cycle, 1 gives 2 cycles, 2 gives 4 cycles. Flip-flops keep their value during the earlier cycles of a context.
- R5: Folding level code 3 keeps context 0 active permanently. The flip-flops load every cycle and `done` never rises.
- R6: When the final context's step completes, `done` is high for exactly one cycle, in the cycle after the last load. The sequencer then returns to idle.
- R7: Table input i takes its value from the 2-bit source field at bits [2i+1:2i]. Code 0 selects external data bit dataIn[4e+i] for element e. Code 1 selects the element's own flip-flop. Code 2 selects the flip-flop of element (e-1) mod 4. Code 3 selects the flip-flop of element (e+1) mod 4.
- R8: With an element's output-select bit at 1, the output is its flip-flop and not the table value.
- R9: A configuration write made while the sequencer runs is discarded, and `cfgErr` goes high for one cycle. A write made while idle raises no error.
- R10: Synchronous reset clears every flip-flop, the sequencer, `done` and `cfgErr`. Stored contexts are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (taken only when idle) |
| foldLevel | input | 2 | 0/1/2 = 1/2/4 cycles per context, 3 = no folding |
| ctxLast | input | 4 | Index of the last context used (count minus one), latched at start |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCtx | input | 4 | Context index of the write |
| cfgLe | input | 2 | Element index of the write |
| cfgTruth | input | 16 | Truth table of the write |
| cfgRegOut | input | 1 | Output select of the write (1 = registered) |
| cfgSrc | input | 8 | Input-source field of the write, 2 bits per table input |
| dataIn | input | 16 | External data, 4 bits per element |
| leOut | output | 4 | Element outputs |
| done | output | 1 | One-cycle pulse when the sequence wraps |
| cfgErr | output | 1 | One-cycle pulse on a rejected write |

## Verification
The assertions assume that `start` is pulsed only after reset has been released. They also assume that `ctxLast` and `foldLevel` are valid when start is taken. These are latched, so later changes have no effect. The bench drives every input on the falling edge and changes settings only while the sequencer is idle. The single exception is a deliberate write during a no-folding run, which checks the rejection path. Every context that a run reads is written first, so no unloaded storage ever reaches a flip-flop.

// File: rtl/fold_pkg.sv
package fold_pkg;
  localparam int NUM_LE  = 4;
  localparam int NUM_CTX = 16;
  localparam int LUT_K   = 4;
  localparam int TT_W    = 1 << LUT_K;
  localparam int SRC_W   = 2 * LUT_K;
  localparam int CTX_W   = $clog2(NUM_CTX);
  localparam int LE_W    = $clog2(NUM_LE);
  localparam int DWELL_W = 2;

  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_OWN = 2'd1, SRC_LEFT = 2'd2, SRC_RIGHT = 2'd3} srcSel_t;
  typedef enum logic [1:0] {FOLD_1 = 2'd0, FOLD_2 = 2'd1, FOLD_4 = 2'd2, FOLD_NONE = 2'd3} foldLevel_t;

  typedef struct packed {
    logic [TT_W-1:0]  truth;
    logic             regOut;
    logic [SRC_W-1:0] src;
  } ctxEntry_t;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             capture;
    logic             clear;
    logic             write;
  } ctrlStrobe_t;
endpackage

// File: rtl/fold_ctrl.sv
module fold_ctrl
  import fold_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       foldLevel,
  input  logic [CTX_W-1:0] ctxLast,
  input  logic             cfgWe,
  output ctrlStrobe_t      strobe,
  output logic             done,
  output logic             cfgErr
);
  logic               running;
  logic [CTX_W-1:0]   ctxCur;
  logic [CTX_W-1:0]   lastReg;
  logic [DWELL_W-1:0] dwell;
  foldLevel_t         levelReg;
  logic               noFold;
  logic               dwellEnd;

  assign noFold   = (levelReg == FOLD_NONE);
  assign dwellEnd = noFold || (dwell == DWELL_W'((1 << levelReg) - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      ctxCur   <= '0;
      lastReg  <= '0;
      dwell    <= '0;
      levelReg <= FOLD_1;
      done     <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      done   <= 1'b0;
      cfgErr <= cfgWe && running;
      if (!running) begin
        if (start) begin
          running  <= 1'b1;
          ctxCur   <= '0;
          dwell    <= '0;
          lastReg  <= ctxLast;
          levelReg <= foldLevel_t'(foldLevel);
        end
      end else if (!noFold) begin
        if (dwellEnd) begin
          dwell <= '0;
          if (ctxCur == lastReg) begin
            ctxCur  <= '0;
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            ctxCur <= ctxCur + 1'b1;
          end
        end else begin
          dwell <= dwell + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.ctx     = ctxCur;
    strobe.capture = running && dwellEnd;
    strobe.clear   = rst;
    strobe.write   = cfgWe && !running;
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_err_needs_write_R9: assert property (@(posedge clk) disable iff (rst) cfgErr |-> $past(cfgWe));
  assert_nofold_ctx_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (running && noFold) |=> (ctxCur == '0));
  assert_ctx_in_range_R3: assert property (@(posedge clk) disable iff (rst) running |-> (ctxCur <= lastReg));
endmodule

// File: rtl/fold_datapath.sv
module fold_datapath
  import fold_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobe_t             strobe,
  input  logic [LE_W-1:0]         cfgLe,
  input  logic [CTX_W-1:0]        cfgCtx,
  input  ctxEntry_t               cfgEntry,
  input  logic [NUM_LE*LUT_K-1:0] dataIn,
  output logic [NUM_LE-1:0]       leOut
);
  ctxEntry_t         ctxMem [NUM_LE][NUM_CTX];
  logic [NUM_LE-1:0] ffQ;
  logic [NUM_LE-1:0] lutVal;

  always_ff @(posedge clk) begin
    if (strobe.write) ctxMem[cfgLe][cfgCtx] <= cfgEntry;
  end

  for (genvar e = 0; e < NUM_LE; e++) begin : g_le
    localparam int LEFT  = (e + NUM_LE - 1) % NUM_LE;
    localparam int RIGHT = (e + 1) % NUM_LE;
    ctxEntry_t        active;
    logic [LUT_K-1:0] lutIdx;

    assign active = ctxMem[e][strobe.ctx];

    for (genvar i = 0; i < LUT_K; i++) begin : g_in
      always_comb begin
        case (srcSel_t'(active.src[2*i +: 2]))
          SRC_EXT:   lutIdx[i] = dataIn[e*LUT_K + i];
          SRC_OWN:   lutIdx[i] = ffQ[e];
          SRC_LEFT:  lutIdx[i] = ffQ[LEFT];
          default:   lutIdx[i] = ffQ[RIGHT];
        endcase
      end
    end

    assign lutVal[e] = active.truth[lutIdx];
    assign leOut[e]  = active.regOut ? ffQ[e] : lutVal[e];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        ffQ <= '0;
    else if (strobe.capture) ffQ <= lutVal;
  end

  assert_ff_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe.capture && !strobe.clear) |=> $stable(ffQ));
  assert_ff_cleared_R10: assert property (@(posedge clk) strobe.clear |=> (ffQ == '0));
  assert_write_idle_only_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.write |-> !strobe.capture);
endmodule

// File: rtl/fold_cluster.sv
module fold_cluster
  import fold_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [1:0]              foldLevel,
  input  logic [CTX_W-1:0]        ctxLast,
  input  logic                    cfgWe,
  input  logic [CTX_W-1:0]        cfgCtx,
  input  logic [LE_W-1:0]         cfgLe,
  input  logic [TT_W-1:0]         cfgTruth,
  input  logic                    cfgRegOut,
  input  logic [SRC_W-1:0]        cfgSrc,
  input  logic [NUM_LE*LUT_K-1:0] dataIn,
  output logic [NUM_LE-1:0]       leOut,
  output logic                    done,
  output logic                    cfgErr
);
  ctrlStrobe_t strobe;
  ctxEntry_t   cfgEntry;

  assign cfgEntry = '{truth: cfgTruth, regOut: cfgRegOut, src: cfgSrc};

  fold_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .foldLevel(foldLevel), .ctxLast(ctxLast),
    .cfgWe(cfgWe), .strobe(strobe), .done(done), .cfgErr(cfgErr)
  );

  fold_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cfgLe(cfgLe), .cfgCtx(cfgCtx),
    .cfgEntry(cfgEntry), .dataIn(dataIn), .leOut(leOut)
  );
endmodule

// File: tb/fold_cluster_bench.sv
`timescale 1ns/1ps
module fold_cluster_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  foldLevel = 2'd0;
  logic [3:0]  ctxLast = 4'd0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgCtx = 4'd0;
  logic [1:0]  cfgLe = 2'd0;
  logic [15:0] cfgTruth = 16'h0;
  logic        cfgRegOut = 1'b0;
  logic [7:0]  cfgSrc = 8'h0;
  logic [15:0] dataIn = 16'h0;
  logic [3:0]  leOut;
  logic        done, cfgErr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fold_cluster u_fold_cluster (
    .clk(clk), .rst(rst), .start(start), .foldLevel(foldLevel), .ctxLast(ctxLast),
    .cfgWe(cfgWe), .cfgCtx(cfgCtx), .cfgLe(cfgLe), .cfgTruth(cfgTruth),
    .cfgRegOut(cfgRegOut), .cfgSrc(cfgSrc), .dataIn(dataIn), .leOut(leOut),
    .done(done), .cfgErr(cfgErr)
  );

  // {truth, inputs, expected}
  localparam logic [20:0] VEC [10] = '{
    {16'h8000, 4'hF, 1'b1}, {16'h8000, 4'hE, 1'b0},
    {16'hFFFE, 4'h0, 1'b0}, {16'hFFFE, 4'h4, 1'b1},
    {16'h6996, 4'h7, 1'b1}, {16'h6996, 4'h3, 1'b0},
    {16'hAAAA, 4'h5, 1'b1}, {16'hAAAA, 4'h4, 1'b0},
    {16'hFF00, 4'h8, 1'b1}, {16'hFF00, 4'h7, 1'b0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic cfgWrite(input logic [1:0] le, input logic [3:0] ctx, input logic [15:0] tt,
                          input logic ro, input logic [7:0] src);
    @(negedge clk);
    cfgWe = 1'b1; cfgLe = le; cfgCtx = ctx; cfgTruth = tt; cfgRegOut = ro; cfgSrc = src;
    @(negedge clk) cfgWe = 1'b0;
  endtask

  task automatic pulseStart(input logic [1:0] lvl);
    foldLevel = lvl;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic runFold(input logic [1:0] lvl, input logic [15:0] din,
                         input logic [3:0] stage1, input logic [3:0] fin);
    int p;
    p = 1 << lvl;
    doReset();
    dataIn = din;
    ctxLast = 4'd1;
    pulseStart(lvl);
    for (int k = 1; k <= 2 * p; k++) begin
      @(negedge clk);
      if (p > 1 && k == p - 1) check(leOut, 4'h0, "R4 hold before dwell end");
      if (k == p) check(leOut, stage1, "R3 stage one result");
      if (k < 2 * p) check(done, 0, "R6 done early");
      else begin
        check(done, 1, "R6 done pulse");
        check(leOut, fin, "R3 R7 folded result");
      end
    end
    @(negedge clk) check(done, 0, "R6 done single cycle");
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    check(done, 0, "R10 reset done");
    check(cfgErr, 0, "R10 reset cfgErr");

    // R1 table walk on element 0, context 0, combinational output
    foreach (VEC[n]) begin
      cfgWrite(2'd0, 4'd0, VEC[n][20:5], 1'b0, 8'h00);
      dataIn = {12'h0, VEC[n][4:1]};
      #1 check(leOut[0], VEC[n][0], "R1 lut lookup");
    end
    check(cfgErr, 0, "R9 idle write no error");

    // R2 element 2 holds its own context
    cfgWrite(2'd2, 4'd0, 16'hAAAA, 1'b0, 8'h00);
    dataIn = 16'h0100;
    #1 check(leOut[2], 1, "R2 element index write");

    // folded two-stage circuit
    cfgWrite(2'd0, 4'd0, 16'h8000, 1'b1, 8'h00);
    cfgWrite(2'd1, 4'd0, 16'hFFFE, 1'b1, 8'h00);
    cfgWrite(2'd2, 4'd0, 16'hFFFF, 1'b1, 8'h00);
    cfgWrite(2'd3, 4'd0, 16'hFFFF, 1'b1, 8'h00);
    cfgWrite(2'd0, 4'd1, 16'h6666, 1'b1, 8'h0D);
    cfgWrite(2'd1, 4'd1, 16'hAAAA, 1'b1, 8'h02);
    cfgWrite(2'd2, 4'd1, 16'hAAAA, 1'b1, 8'h02);
    cfgWrite(2'd3, 4'd1, 16'hAAAA, 1'b1, 8'h02);
    runFold(2'd0, 16'h000F, 4'b1101, 4'b1011);
    runFold(2'd1, 16'h002F, 4'b1111, 4'b1110);
    runFold(2'd2, 16'h0007, 4'b1100, 4'b1000);
    runFold(2'd0, 16'h002F, 4'b1111, 4'b1110);

    // R5 no folding: element 0 toggles via own flip-flop
    cfgWrite(2'd0, 4'd0, 16'h5555, 1'b1, 8'h01);
    doReset();
    check(leOut[0], 0, "R8 registered output after reset");
    pulseStart(2'd3);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(leOut[0], k % 2, "R5 nofold toggle");
      check(done, 0, "R5 no done");
    end
    // R9 write while running
    @(negedge clk);
    check(leOut[0], 1, "R5 nofold toggle");
    cfgWe = 1'b1; cfgLe = 2'd0; cfgCtx = 4'd0; cfgTruth = 16'h0000; cfgRegOut = 1'b1; cfgSrc = 8'h00;
    @(negedge clk) cfgWe = 1'b0;
    check(cfgErr, 1, "R9 error pulse");
    check(leOut[0], 0, "R9 running continues");
    @(negedge clk);
    check(cfgErr, 0, "R9 error one cycle");
    check(leOut[0], 1, "R9 write ignored");

    // R10 reset keeps contexts
    doReset();
    check(leOut[0], 0, "R10 flip-flop cleared");
    check(done, 0, "R10 done cleared");
    pulseStart(2'd3);
    @(negedge clk) check(leOut[0], 1, "R10 context kept");
    @(negedge clk) check(leOut[0], 0, "R10 context kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule